// File: doc/BRIEF.md
# Predicated Vector Element Step Sequencer

This block walks the element loop of one vector instruction whose elements may be split into small sub-vectors of one to four lanes. The source side and the destination side each keep an element step and a sub-element step of their own, and they advance independently. A side whose predicate mask has a clear bit passes over that element, unless the side is in zeroing mode. It does this only when its sub-step is zero, so a sub-vector that has been started is never left half done. From the current steps the block produces flat element indices, forward or mirrored, that feed register address generation.

A one-cycle `start_i` pulse clears all four counters and opens the loop. While `valid_o` is high, the current source and destination steps and indices describe one element operation. A one-cycle `advance_i` pulse moves on to the next one. The loop closes when either side reaches its final sub-element, or when predicate skipping runs a side off the end of the vector. `done_o` then rises and stays high until the next start. The vector length, the sub-vector code, the masks and the mode inputs must be held steady from start until done.

Top module: `vstep_seq`

## Requirements
- R1: A `start_i` pulse clears both element steps and both sub-steps to 0 and clears `done_o` when `vl_i` is nonzero. The steps shown afterwards are 0 unless predicate skipping applies per R3.
- R2: When `advance_i` is pulsed while `valid_o` is high and `loop_end_o` is low, each side is updated on its own. If its sub-step is below `subvl_i`, the sub-step increments and the shown element step is kept. If the sub-step equals `subvl_i`, the sub-step returns to 0 and the element step becomes the shown step plus one.
- R3: When a side's zero flag is 0 and its sub-step is 0, the shown step of that side is the lowest index at or above the stored step whose mask bit (bit i for element i) is 1. If no such index lies below `vl_i`, the shown step is `vl_i`.
- R4: When a side's zero flag is 1, that side never skips elements. Elements with a clear mask bit are still issued.
- R5: When either shown step equals `vl_i`, `valid_o` is low and `done_o` rises at the next clock edge.
- R6: `loop_end_o` is high exactly when `valid_o` is high and either side is at (step = `vl_i`−1 and sub-step = `subvl_i`). Advancing while it is high ends the loop: `done_o` rises at the next edge and the counters return to 0.
- R7: Each side's index equals step × (`subvl_i`+1) + sub-step.
- R8: When `reverse_i` is 1, each index becomes `vl_i`×(`subvl_i`+1) − 1 minus the forward index.
- R9: `done_o` stays high until the next `start_i`, and `advance_i` has no effect while it is high.
- R10: Starting with `vl_i` = 0 sets `done_o` at the start edge itself, and `valid_o` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vl_i | input | 7 | Vector length, 0 to 64 |
| subvl_i | input | 2 | Sub-vector code: lanes per element minus one |
| src_mask_i | input | 64 | Source predicate mask, bit i for element i |
| dst_mask_i | input | 64 | Destination predicate mask |
| src_zero_i | input | 1 | Source zeroing mode (no skipping) |
| dst_zero_i | input | 1 | Destination zeroing mode (no skipping) |
| reverse_i | input | 1 | Mirror the produced indices |
| start_i | input | 1 | One-cycle pulse that opens a new loop |
| advance_i | input | 1 | One-cycle pulse that moves to the next element operation |
| src_step_o | output | 7 | Shown source element step |
| dst_step_o | output | 7 | Shown destination element step |
| src_sub_o | output | 2 | Source sub-step |
| dst_sub_o | output | 2 | Destination sub-step |
| src_idx_o | output | 9 | Source element index |
| dst_idx_o | output | 9 | Destination element index |
| valid_o | output | 1 | Current steps describe an element operation |
| loop_end_o | output | 1 | Current operation is the last of the loop |
| done_o | output | 1 | Loop finished; held until next start |

## Verification
Steps, indices, `valid_o` and `loop_end_o` follow the registered counters through combinational logic only. They are therefore due in the same cycle as the edge that sampled `start_i` or `advance_i`. `done_o` is registered. It is due one edge after the exhausting state appears, or after the advance that met loop end, and in the same edge as a start with zero length. The bench drives on the falling edge and compares against its own loop model at the following falling edge. Each comparison thus lands exactly one rising edge after its stimulus, and a second check after exhaustion catches a `done_o` that is one edge late.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
   localparam int SIDES   = 2;
   localparam int SIDE_SRC = 0;
   localparam int SIDE_DST = 1;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_DONE   = 2'd2
   } seq_state_e;
endpackage

// File: rtl/vstep_skip.sv
module vstep_skip #(
   parameter int VL_W   = 7,
   parameter int MASK_W = 64
) (
   input  logic [VL_W-1:0]   from_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [MASK_W-1:0] mask_i,
   output logic [VL_W-1:0]   first_o
);
   initial begin
      if (MASK_W >= (1 << VL_W))
         $error("vstep_skip: MASK_W must fit below 2**VL_W");
   end

   always_comb begin
      logic hit;
      hit     = 1'b0;
      first_o = vl_i;
      for (int i = 0; i < MASK_W; i++) begin
         if (!hit && (VL_W'(i) >= from_i) && (VL_W'(i) < vl_i) && mask_i[i]) begin
            hit     = 1'b1;
            first_o = VL_W'(i);
         end
      end
   end
endmodule

// File: rtl/vstep_side.sv
module vstep_side #(
   parameter int VL_W   = 7,
   parameter int SUB_W  = 2,
   parameter int MASK_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [SUB_W-1:0]  code_i,
   input  logic [MASK_W-1:0] mask_i,
   input  logic              zero_i,
   input  logic              clr_i,
   input  logic              adv_i,
   output logic [VL_W-1:0]   step_o,
   output logic [SUB_W-1:0]  sub_o
);
   logic [VL_W-1:0]  step_q;
   logic [SUB_W-1:0] sub_q;
   logic [VL_W-1:0]  found;
   logic             skip_en;

   vstep_skip #(.VL_W(VL_W), .MASK_W(MASK_W)) u_skip (
      .from_i (step_q),
      .vl_i   (vl_i),
      .mask_i (mask_i),
      .first_o(found)
   );

   assign skip_en = !zero_i && (sub_q == '0);
   assign step_o  = skip_en ? found : step_q;
   assign sub_o   = sub_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
         sub_q  <= '0;
      end else if (clr_i) begin
         step_q <= '0;
         sub_q  <= '0;
      end else if (adv_i) begin
         if (sub_q == code_i) begin
            sub_q  <= '0;
            step_q <= (step_o == vl_i - 1'b1) ? step_o : step_o + 1'b1;
         end else begin
            sub_q  <= sub_q + 1'b1;
            step_q <= step_o;
         end
      end
   end

   assert_sub_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !clr_i && (sub_q != code_i) |=> (sub_q == $past(sub_q) + 1'b1));
   assert_no_skip_zeroing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      zero_i |-> (step_o == step_q));
endmodule

// File: rtl/vstep_index.sv
module vstep_index #(
   parameter int VL_W   = 7,
   parameter int SUB_W  = 2,
   parameter bit REV_EN = 1'b1,
   localparam int IDX_W = VL_W + SUB_W
) (
   input  logic [VL_W-1:0]  step_i,
   input  logic [SUB_W-1:0] sub_i,
   input  logic [SUB_W-1:0] code_i,
   input  logic [VL_W-1:0]  vl_i,
   input  logic             rev_i,
   output logic [IDX_W-1:0] idx_o
);
   logic [IDX_W-1:0] lanes;
   logic [IDX_W-1:0] fwd;

   assign lanes = IDX_W'(code_i) + 1'b1;
   assign fwd   = IDX_W'(step_i) * lanes + IDX_W'(sub_i);

   generate
      if (REV_EN) begin : g_rev
         logic [IDX_W-1:0] vmax;
         assign vmax  = IDX_W'(vl_i) * lanes;
         assign idx_o = rev_i ? (vmax - 1'b1 - fwd) : fwd;
      end else begin : g_fwd
         logic unused_rev;
         assign unused_rev = rev_i ^ (|vl_i);
         assign idx_o      = fwd;
      end
   endgenerate
endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
   import vstep_pkg::*;
#(
   parameter int VL_W   = 7,
   parameter int SUB_W  = 2,
   parameter int MASK_W = 64,
   parameter bit REV_EN = 1'b1,
   localparam int IDX_W = VL_W + SUB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [SUB_W-1:0]  subvl_i,
   input  logic [MASK_W-1:0] src_mask_i,
   input  logic [MASK_W-1:0] dst_mask_i,
   input  logic              src_zero_i,
   input  logic              dst_zero_i,
   input  logic              reverse_i,
   input  logic              start_i,
   input  logic              advance_i,
   output logic [VL_W-1:0]   src_step_o,
   output logic [VL_W-1:0]   dst_step_o,
   output logic [SUB_W-1:0]  src_sub_o,
   output logic [SUB_W-1:0]  dst_sub_o,
   output logic [IDX_W-1:0]  src_idx_o,
   output logic [IDX_W-1:0]  dst_idx_o,
   output logic              valid_o,
   output logic              loop_end_o,
   output logic              done_o
);
   initial begin
      if (MASK_W >= (1 << VL_W)) $error("vstep_seq: VL_W too narrow for MASK_W");
      if (SUB_W < 1)             $error("vstep_seq: SUB_W must be at least 1");
   end

   seq_state_e state_q;
   logic [SIDES-1:0][MASK_W-1:0] masks;
   logic [SIDES-1:0]             zeros;
   logic [SIDES-1:0][VL_W-1:0]   steps;
   logic [SIDES-1:0][SUB_W-1:0]  subs;
   logic [SIDES-1:0][IDX_W-1:0]  idxs;
   logic [SIDES-1:0]             at_end;
   logic [SIDES-1:0]             ran_out;
   logic active, exhausted, finish, clr, adv;

   assign masks[SIDE_SRC] = src_mask_i;
   assign masks[SIDE_DST] = dst_mask_i;
   assign zeros[SIDE_SRC] = src_zero_i;
   assign zeros[SIDE_DST] = dst_zero_i;

   assign active    = (state_q == ST_ACTIVE);
   assign exhausted = |ran_out;
   assign valid_o   = active && !exhausted;
   assign loop_end_o = valid_o && (|at_end);
   assign finish    = active && (exhausted || (advance_i && loop_end_o));
   assign clr       = start_i || finish;
   assign adv       = valid_o && advance_i;

   generate
      for (genvar g = 0; g < SIDES; g++) begin : g_side
         vstep_side #(.VL_W(VL_W), .SUB_W(SUB_W), .MASK_W(MASK_W)) u_side (
            .clk   (clk),
            .rst_n (rst_n),
            .vl_i  (vl_i),
            .code_i(subvl_i),
            .mask_i(masks[g]),
            .zero_i(zeros[g]),
            .clr_i (clr),
            .adv_i (adv),
            .step_o(steps[g]),
            .sub_o (subs[g])
         );
         vstep_index #(.VL_W(VL_W), .SUB_W(SUB_W), .REV_EN(REV_EN)) u_idx (
            .step_i(steps[g]),
            .sub_i (subs[g]),
            .code_i(subvl_i),
            .vl_i  (vl_i),
            .rev_i (reverse_i),
            .idx_o (idxs[g])
         );
         assign ran_out[g] = (steps[g] >= vl_i);
         assign at_end[g]  = (steps[g] == vl_i - 1'b1) && (subs[g] == subvl_i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else if (start_i) begin
         state_q <= (vl_i == '0) ? ST_DONE : ST_ACTIVE;
      end else if (finish) begin
         state_q <= ST_DONE;
      end
   end

   assign done_o     = (state_q == ST_DONE);
   assign src_step_o = steps[SIDE_SRC];
   assign dst_step_o = steps[SIDE_DST];
   assign src_sub_o  = subs[SIDE_SRC];
   assign dst_sub_o  = subs[SIDE_DST];
   assign src_idx_o  = idxs[SIDE_SRC];
   assign dst_idx_o  = idxs[SIDE_DST];

   assert_start_clears_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && (vl_i != '0) |=> !done_o && (src_sub_o == '0) && (dst_sub_o == '0));
   assert_skip_lands_on_set_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !src_zero_i && (src_sub_o == '0) |-> ((src_mask_i >> src_step_o) & 64'd1) != 0);
   assert_exhaust_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active && !valid_o && !start_i |=> done_o);
   assert_loop_end_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      loop_end_o && advance_i && !start_i |=> done_o && !valid_o);
   assert_valid_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (src_step_o < vl_i) && (dst_step_o < vl_i)
                  && (src_sub_o <= subvl_i) && (dst_sub_o <= subvl_i));
   assert_done_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> done_o);
   assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && (vl_i == '0) |=> done_o && !valid_o);
endmodule

// File: tb/tb_vstep_seq.sv
module tb_vstep_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  vl_i = '0;
   logic [1:0]  subvl_i = '0;
   logic [63:0] src_mask_i = '0, dst_mask_i = '0;
   logic        src_zero_i = 0, dst_zero_i = 0, reverse_i = 0;
   logic        start_i = 0, advance_i = 0;
   logic [6:0]  src_step_o, dst_step_o;
   logic [1:0]  src_sub_o, dst_sub_o;
   logic [8:0]  src_idx_o, dst_idx_o;
   logic        valid_o, loop_end_o, done_o;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   vstep_seq dut (
      .clk(clk), .rst_n(rst_n), .vl_i(vl_i), .subvl_i(subvl_i),
      .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
      .src_zero_i(src_zero_i), .dst_zero_i(dst_zero_i), .reverse_i(reverse_i),
      .start_i(start_i), .advance_i(advance_i),
      .src_step_o(src_step_o), .dst_step_o(dst_step_o),
      .src_sub_o(src_sub_o), .dst_sub_o(dst_sub_o),
      .src_idx_o(src_idx_o), .dst_idx_o(dst_idx_o),
      .valid_o(valid_o), .loop_end_o(loop_end_o), .done_o(done_o)
   );

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (vl=%0d code=%0d zs=%0d zd=%0d rev=%0d)",
                  req, what, act, exp, vl_i, subvl_i, src_zero_i, dst_zero_i, reverse_i);
      end
   endtask

   function automatic int skip_to(int st, logic [63:0] m, int vl);
      while (st < vl && !m[st]) st++;
      return st;
   endfunction

   function automatic int ref_idx(int st, int sb, int code, int vl, bit rev);
      int f;
      f = st * (code + 1) + sb;
      return rev ? (vl * (code + 1) - 1 - f) : f;
   endfunction

   task automatic run(int vl, int code, logic [63:0] sm, logic [63:0] dm,
                      bit zs, bit zd, bit rev);
      int rs, rd, rss, rds, es, ed;
      bit le;
      vl_i = 7'(vl); subvl_i = 2'(code); src_mask_i = sm; dst_mask_i = dm;
      src_zero_i = zs; dst_zero_i = zd; reverse_i = rev;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (vl == 0) begin
         check("R10", "done after zero-length start", done_o, 1);
         check("R10", "valid after zero-length start", valid_o, 0);
         @(negedge clk);
         check("R10", "done held", done_o, 1);
         return;
      end
      check("R1", "done cleared by start", done_o, 0);
      rs = 0; rd = 0; rss = 0; rds = 0;
      for (int it = 0; it < 300; it++) begin
         es = (rss == 0 && !zs) ? skip_to(rs, sm, vl) : rs;
         ed = (rds == 0 && !zd) ? skip_to(rd, dm, vl) : rd;
         if (es == vl || ed == vl) begin
            check("R5", "valid when exhausted", valid_o, 0);
            @(negedge clk);
            check("R5", "done after exhaustion", done_o, 1);
            return;
         end
         check("R3", "src step", src_step_o, es);
         check("R3", "dst step", dst_step_o, ed);
         check("R2", "src sub", src_sub_o, rss);
         check("R2", "dst sub", dst_sub_o, rds);
         check(rev ? "R8" : "R7", "src idx", src_idx_o, ref_idx(es, rss, code, vl, rev));
         check(rev ? "R8" : "R7", "dst idx", dst_idx_o, ref_idx(ed, rds, code, vl, rev));
         check("R5", "valid", valid_o, 1);
         le = (es == vl - 1 && rss == code) || (ed == vl - 1 && rds == code);
         check("R6", "loop end", loop_end_o, int'(le));
         advance_i = 1'b1;
         @(negedge clk);
         advance_i = 1'b0;
         if (le) begin
            check("R6", "done after loop end", done_o, 1);
            check("R6", "valid after loop end", valid_o, 0);
            advance_i = 1'b1;
            @(negedge clk);
            advance_i = 1'b0;
            check("R9", "done ignores advance", done_o, 1);
            return;
         end
         if (rss == code) begin rss = 0; rs = (es == vl - 1) ? es : es + 1; end
         else begin rss++; rs = es; end
         if (rds == code) begin rds = 0; rd = (ed == vl - 1) ? ed : ed + 1; end
         else begin rds++; rd = ed; end
      end
      check("R6", "loop did not terminate", 1, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int vls[6] = '{0, 1, 2, 5, 13, 64};
      logic [63:0] sm, dm;
      repeat (3) @(negedge clk);
      check("R1", "done at reset", done_o, 0);
      check("R1", "valid at reset", valid_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: steps start at 0 with full masks
      vl_i = 7'd4; src_mask_i = '1; dst_mask_i = '1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R1", "src step after start", src_step_o, 0);
      check("R1", "dst step after start", dst_step_o, 0);
      // R4: zeroing mode keeps element 0 although its bit is clear
      src_mask_i = 64'h0; src_zero_i = 1'b1; dst_zero_i = 1'b1;
      @(negedge clk);
      check("R4", "zeroing issues cleared element", valid_o, 1);
      for (int code = 0; code < 4; code++)
         for (int v = 0; v < 6; v++)
            for (int z = 0; z < 4; z++)
               for (int rv = 0; rv < 2; rv++)
                  for (int mk = 0; mk < 3; mk++) begin
                     case (mk)
                        0: begin sm = '1; dm = '1; end
                        1: begin sm = 64'hAAAA_5555_F0F0_3C3C; dm = 64'h5555_AAAA_0F0F_C3C2; end
                        default: begin sm = {$urandom, $urandom}; dm = {$urandom, $urandom}; end
                     endcase
                     run(vls[v], code, sm, dm, z[0], z[1], rv[0]);
                  end
      // R5: empty source mask without zeroing ends at once
      run(8, 1, 64'h0, '1, 1'b0, 1'b0, 1'b0);
      // R3: sparse masks with a sub-vector in progress
      run(20, 2, 64'h0008_0101, 64'h000F_0000, 1'b0, 1'b0, 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule